// File: doc/BRIEF.md
# ATM Cell Transmit Port with Header Check Octet

This block takes ATM cells written into it one octet at a time, without their header check octet, and keeps them in an internal store that holds 32 cells. It sends them out on a cell-bus transmit interface. Every word on that interface is gated by a two-signal, octet-level handshake. As each cell leaves, the port works out the header check octet and inserts it after the four header octets. Cells are written as 52 octets: the 4 header octets first, then the 48 payload octets.

The port's role and bus width are chosen at start-up. It can act as the ATM-layer side, where it drives an active-low enable and watches the partner's active-high cell-available signal. It can also act as the PHY-layer side, where it drives an active-high cell-available signal and watches the partner's active-low enable. The bus is either 8 or 16 bits wide. Both choices are taken from configuration pins on the first clock after reset and then held until the next reset. The design uses one clock.

Top module: `utx_tx_port`

## Requirements
- R1: From reset until the first word is offered, `tx_data` is 0, `tx_soc` is 0 and `in_ready` is 1. `hs_out` rests at its idle level: 1 in the ATM role and 0 in the PHY role.
- R2: `cfg_phy_side` and `cfg_wide_bus` are captured on the first rising clock edge after reset is released. Later changes to them have no effect on polarity, bus width or word layout until the next reset.
- R3: A cell is offered only when all 52 of its octets are stored. With 51 octets stored, `hs_out` stays idle and no word is transferred.
- R4: In 8-bit mode a cell is 53 words, all carried in `tx_data[7:0]` with `tx_data[15:8]` = 0. The order is header octets 1 to 4, then the check octet, then payload octets 1 to 48.
- R5: In 16-bit mode a cell is 27 words, with the earlier octet in `tx_data[15:8]`. Words 1 and 2 carry header octets 1/2 and 3/4. Word 3 carries the check octet in the upper half and 0x00 in the lower half. Words 4 to 27 carry the payload octets in pairs.
- R6: The check octet is a CRC-8 with generator x^8+x^2+x+1, starting from zero and taken MSB first over header octets 1 to 4, then XORed with 0x55.
- R7: `tx_soc` is 1 together with the first word of each cell and 0 on every other word.
- R8: A word moves on a rising edge only when both handshake signals are active. In the ATM role that means `hs_out`=0 and `hs_in`=1. In the PHY role it means `hs_out`=1 and `hs_in`=0. While the partner is inactive, no word moves.
- R9: While a word is offered and the partner is inactive, `tx_data` and `tx_soc` hold their values. Transfer resumes with that same word.
- R10: `in_ready` stays 1 until 32 complete cells (1664 octets) are stored and is 0 when the store is full.
- R11: A started cell is always sent whole. When another complete cell is stored, its first word is offered in the cycle right after the previous cell's last word moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_phy_side | input | 1 | Role select: 1 = PHY-layer side, 0 = ATM-layer side |
| cfg_wide_bus | input | 1 | Bus width select: 1 = 16-bit, 0 = 8-bit |
| in_valid | input | 1 | Write strobe for an incoming cell octet |
| in_data | input | 8 | Incoming cell octet |
| in_ready | output | 1 | Store can accept an octet |
| hs_out | output | 1 | Port's handshake: enable (active low) or cell-available (active high) |
| hs_in | input | 1 | Partner's handshake: cell-available (active high) or enable (active low) |
| tx_data | output | 16 | Outgoing word |
| tx_soc | output | 1 | Start of cell, marks the first word |

## Verification
Two events can land on the same clock edge: the partner withdrawing its handshake, and the port reaching a word with special meaning, such as the inserted check-octet word or the last word of a cell with another cell queued behind it. The stall test blocks the partner on every third cycle of a two-cell, 16-bit transfer, so stalls fall on both of those words. A monitor records every word offered during a stall and requires the next transferred word to match it. The full transferred sequence, including the check octet and pad, is then compared word by word against values computed from the cell contents.

// File: rtl/utx_pkg.sv
package utx_pkg;

   localparam logic [7:0] HEC_COSET = 8'h55;

   // One octet through the x^8+x^2+x+1 divider, most significant bit first
   function automatic logic [7:0] hec_step(input logic [7:0] crc, input logic [7:0] oct);
      logic [7:0] c;
      c = crc ^ oct;
      for (int b = 0; b < 8; b++) begin
         c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
      end
      return c;
   endfunction

endpackage

// File: rtl/utx_cell_fifo.sv
module utx_cell_fifo #(
   parameter int OCT_W     = 8,
   parameter int CELL_OCTS = 52,
   parameter int CELLS     = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid,
   input  logic [OCT_W-1:0] wr_data,
   output logic             wr_ready,
   input  logic [1:0]       pop_cnt,
   input  logic             cell_start,
   output logic [OCT_W-1:0] head0,
   output logic [OCT_W-1:0] head1,
   output logic             cell_ready
);
   localparam int DEPTH = CELLS * CELL_OCTS;
   localparam int AW    = $clog2(DEPTH);
   localparam int UW    = $clog2(DEPTH + 1);
   localparam int CW    = $clog2(CELLS + 1);
   localparam int OW    = $clog2(CELL_OCTS);

   initial begin
      assert (CELLS >= 1) else $error("store needs at least one cell");
      assert (CELL_OCTS >= 2) else $error("cell too short");
   end

   logic [OCT_W-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic [UW-1:0]    used;
   logic [CW-1:0]    full_cells;
   logic [OW-1:0]    wr_oct;
   logic             wr_fire, wr_last;

   function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] p, input logic [1:0] n);
      logic [AW:0] s;
      s = {1'b0, p} + (AW+1)'(n);
      if (s >= (AW+1)'(DEPTH)) s = s - (AW+1)'(DEPTH);
      return s[AW-1:0];
   endfunction

   assign wr_ready   = used < UW'(DEPTH);
   assign wr_fire    = wr_valid & wr_ready;
   assign wr_last    = wr_oct == OW'(CELL_OCTS - 1);
   assign cell_ready = full_cells != '0;
   assign head0      = mem[rp];
   assign head1      = mem[wrap_add(rp, 2'd1)];

   always_ff @(posedge clk) begin
      if (wr_fire) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp         <= '0;
         rp         <= '0;
         used       <= '0;
         full_cells <= '0;
         wr_oct     <= '0;
      end else begin
         if (wr_fire) begin
            wp     <= wrap_add(wp, 2'd1);
            wr_oct <= wr_last ? '0 : wr_oct + 1'b1;
         end
         rp         <= wrap_add(rp, pop_cnt);
         used       <= used + UW'(wr_fire) - UW'(pop_cnt);
         full_cells <= full_cells + CW'(wr_fire & wr_last) - CW'(cell_start);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      used <= UW'(DEPTH)); // R10
   AST_START_NEEDS_CELL: assert property (@(posedge clk) disable iff (!rst_n)
      cell_start |-> full_cells != '0); // R3
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_cnt != 2'd0) |-> used >= UW'(pop_cnt)); // R11

endmodule

// File: rtl/utx_hec.sv
module utx_hec
   import utx_pkg::*;
#(
   parameter int OCT_W = 8,
   parameter int LANES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   upd,
   input  logic                   first,
   input  logic [NW-1:0]          n_oct,
   input  logic [LANES*OCT_W-1:0] oct_in,
   output logic [OCT_W-1:0]       hec_out
);
   localparam int NW = $clog2(LANES + 1);

   initial begin
      assert (OCT_W == 8) else $error("check octet is defined on 8-bit octets");
      assert (LANES >= 1) else $error("need at least one lane");
   end

   logic [7:0] crc_q;
   logic [7:0] chain [LANES+1];

   assign chain[0] = first ? 8'h00 : crc_q;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign chain[g+1] = (n_oct > NW'(g)) ? hec_step(chain[g], oct_in[g*OCT_W +: OCT_W])
                                           : chain[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) crc_q <= '0;
      else if (upd) crc_q <= chain[LANES];
   end

   assign hec_out = crc_q ^ HEC_COSET;

   AST_HEC_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      upd |-> (n_oct != '0) && (n_oct <= NW'(LANES))); // R6

endmodule

// File: rtl/utx_word_seq.sv
module utx_word_seq #(
   parameter int OCT_W    = 8,
   parameter int HDR_OCTS = 4,
   parameter int PAY_OCTS = 48
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               wide,
   input  logic               cell_ready,
   input  logic               xfer,
   input  logic [OCT_W-1:0]   head0,
   input  logic [OCT_W-1:0]   head1,
   input  logic [OCT_W-1:0]   hec,
   output logic               active,
   output logic [2*OCT_W-1:0] word,
   output logic               soc,
   output logic [1:0]         pop_cnt,
   output logic               cell_start,
   output logic               hec_upd,
   output logic               hec_first,
   output logic [1:0]         hec_n,
   output logic [2*OCT_W-1:0] hec_lanes
);
   localparam int W8    = HDR_OCTS + 1 + PAY_OCTS;
   localparam int W16   = HDR_OCTS / 2 + 1 + PAY_OCTS / 2;
   localparam int IW    = $clog2(W8);
   localparam int HEC8  = HDR_OCTS;
   localparam int HEC16 = HDR_OCTS / 2;

   initial begin
      assert (HDR_OCTS % 2 == 0) else $error("header must split into 16-bit words");
      assert (PAY_OCTS % 2 == 0) else $error("payload must split into 16-bit words");
   end

   logic          in_cell;
   logic [IW-1:0] widx;
   logic          is_hec, is_hdr, is_last;

   assign is_hec  = widx == (wide ? IW'(HEC16) : IW'(HEC8));
   assign is_hdr  = widx <  (wide ? IW'(HEC16) : IW'(HEC8));
   assign is_last = widx == (wide ? IW'(W16 - 1) : IW'(W8 - 1));

   assign active = en & (in_cell | cell_ready);
   assign soc    = active & ~in_cell;

   always_comb begin
      if (is_hec) word = wide ? {hec, {OCT_W{1'b0}}} : {{OCT_W{1'b0}}, hec};
      else        word = wide ? {head0, head1}       : {{OCT_W{1'b0}}, head0};
   end

   assign pop_cnt    = (xfer & ~is_hec) ? (wide ? 2'd2 : 2'd1) : 2'd0;
   assign cell_start = xfer & ~in_cell;
   assign hec_upd    = xfer & is_hdr;
   assign hec_first  = ~in_cell;
   assign hec_n      = wide ? 2'd2 : 2'd1;
   assign hec_lanes  = {head1, head0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_cell <= 1'b0;
         widx    <= '0;
      end else if (xfer) begin
         if (is_last) begin
            in_cell <= 1'b0;
            widx    <= '0;
         end else begin
            in_cell <= 1'b1;
            widx    <= widx + 1'b1;
         end
      end
   end

   AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !xfer) |=> active && $stable(word) && $stable(soc)); // R9
   AST_XFER_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |-> active); // R8
   AST_SOC_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && soc) |=> !soc); // R7

endmodule

// File: rtl/utx_tx_port.sv
module utx_tx_port #(
   parameter int OCT_W      = 8,
   parameter int HDR_OCTS   = 4,
   parameter int PAY_OCTS   = 48,
   parameter int FIFO_CELLS = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_phy_side,
   input  logic               cfg_wide_bus,
   input  logic               in_valid,
   input  logic [OCT_W-1:0]   in_data,
   output logic               in_ready,
   output logic               hs_out,
   input  logic               hs_in,
   output logic [2*OCT_W-1:0] tx_data,
   output logic               tx_soc
);
   localparam int CELL_OCTS = HDR_OCTS + PAY_OCTS;

   initial begin
      assert (HDR_OCTS == 4) else $error("check octet covers exactly four header octets");
      assert (OCT_W == 8) else $error("octet width must be 8");
   end

   logic             cfg_lock, phy_q, wide_q, role;
   logic             active, xfer, partner_ok;
   logic [1:0]       pop_cnt, hec_n;
   logic             cell_start, cell_ready;
   logic [OCT_W-1:0] head0, head1, hec;
   logic             hec_upd, hec_first;
   logic [2*OCT_W-1:0] word, hec_lanes;
   logic             soc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_lock <= 1'b0;
         phy_q    <= 1'b0;
         wide_q   <= 1'b0;
      end else if (!cfg_lock) begin
         cfg_lock <= 1'b1;
         phy_q    <= cfg_phy_side;
         wide_q   <= cfg_wide_bus;
      end
   end

   assign role       = cfg_lock ? phy_q : cfg_phy_side;
   assign partner_ok = phy_q ? ~hs_in : hs_in;
   assign xfer       = active & partner_ok;
   assign hs_out     = role ? active : ~active;
   assign tx_data    = active ? word : '0;
   assign tx_soc     = soc;

   utx_cell_fifo #(.OCT_W(OCT_W), .CELL_OCTS(CELL_OCTS), .CELLS(FIFO_CELLS)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr_valid(in_valid), .wr_data(in_data), .wr_ready(in_ready),
      .pop_cnt(pop_cnt), .cell_start(cell_start), .head0(head0), .head1(head1),
      .cell_ready(cell_ready)
   );

   utx_word_seq #(.OCT_W(OCT_W), .HDR_OCTS(HDR_OCTS), .PAY_OCTS(PAY_OCTS)) u_seq (
      .clk(clk), .rst_n(rst_n), .en(cfg_lock), .wide(wide_q), .cell_ready(cell_ready),
      .xfer(xfer), .head0(head0), .head1(head1), .hec(hec), .active(active), .word(word),
      .soc(soc), .pop_cnt(pop_cnt), .cell_start(cell_start), .hec_upd(hec_upd),
      .hec_first(hec_first), .hec_n(hec_n), .hec_lanes(hec_lanes)
   );

   utx_hec #(.OCT_W(OCT_W), .LANES(2)) u_hec (
      .clk(clk), .rst_n(rst_n), .upd(hec_upd), .first(hec_first), .n_oct(hec_n),
      .oct_in(hec_lanes), .hec_out(hec)
   );

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_lock |=> $stable(phy_q) && $stable(wide_q)); // R2

endmodule

// File: tb/tb_utx_tx_port.sv
module tb_utx_tx_port;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        cfg_phy_side = 0, cfg_wide_bus = 0;
   logic        in_valid = 0;
   logic [7:0]  in_data = 0;
   logic        in_ready, hs_out, tx_soc;
   logic        hs_in = 0;
   logic [15:0] tx_data;

   utx_tx_port dut (
      .clk(clk), .rst_n(rst_n), .cfg_phy_side(cfg_phy_side), .cfg_wide_bus(cfg_wide_bus),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .hs_out(hs_out),
      .hs_in(hs_in), .tx_data(tx_data), .tx_soc(tx_soc)
   );

   always #10 clk = ~clk;

   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit b_phy = 0, partner_on = 0, stall_en = 0;
   logic [16:0] cap [0:4095];
   int  cap_cyc [0:4095];
   int  cap_n = 0, hold_bad = 0, hold_seen = 0;
   bit  hold_pend = 0;
   logic [16:0] held;

   always @(posedge clk) cyc++;

   // partner model and word monitor
   always @(negedge clk) begin
      bit pon, ours;
      pon = partner_on && !(stall_en && (cyc % 3 == 1));
      hs_in = b_phy ? !pon : pon;
      #1;
      ours = b_phy ? hs_out : !hs_out;
      if (rst_n && ours) begin
         if (pon) begin
            if (hold_pend && {tx_soc, tx_data} !== held) hold_bad++;
            hold_pend = 0;
            if (cap_n < 4096) begin
               cap[cap_n] = {tx_soc, tx_data};
               cap_cyc[cap_n] = cyc;
            end
            cap_n++;
         end else begin
            if (hold_pend && {tx_soc, tx_data} !== held) hold_bad++;
            held = {tx_soc, tx_data};
            hold_pend = 1;
            hold_seen++;
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] co(input int seed, input int k);
      return 8'(seed * 37 + k * 11 + 3);
   endfunction

   function automatic logic [7:0] bench_hec(input int seed);
      logic [7:0] c = 8'h00;
      for (int k = 0; k < 4; k++) begin
         for (int b = 7; b >= 0; b--) begin
            logic fb;
            fb = c[7] ^ co(seed, k)[b];
            c = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
         end
      end
      return c ^ 8'h55;
   endfunction

   function automatic logic [15:0] exp_word(input int seed, input int i, input bit wide);
      if (!wide) begin
         if (i < 4) return {8'h00, co(seed, i)};
         if (i == 4) return {8'h00, bench_hec(seed)};
         return {8'h00, co(seed, i - 1)};
      end
      if (i < 2) return {co(seed, 2 * i), co(seed, 2 * i + 1)};
      if (i == 2) return {bench_hec(seed), 8'h00};
      return {co(seed, 2 * i - 2), co(seed, 2 * i - 1)};
   endfunction

   task automatic verify(input string req, input int seed0, input int ncell, input bit wide);
      int wpc = wide ? 27 : 53;
      for (int c = 0; c < ncell; c++)
         for (int i = 0; i < wpc; i++)
            check(req, 32'(cap[c * wpc + i]), 32'({i == 0, exp_word(seed0 + c, i, wide)}));
   endtask

   task automatic put_oct(input logic [7:0] d);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1;
      in_data = d;
      @(posedge clk);
      #1 in_valid = 0;
   endtask

   task automatic put_cell(input int seed);
      for (int k = 0; k < 52; k++) put_oct(co(seed, k));
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input bit phy, input bit wide);
      partner_on = 0; stall_en = 0; b_phy = phy;
      cfg_phy_side = phy; cfg_wide_bus = wide;
      @(negedge clk);
      rst_n = 0;
      idle(3);
      cap_n = 0; hold_bad = 0; hold_seen = 0; hold_pend = 0;
      rst_n = 1;
      idle(2);
   endtask

   task automatic t_reset;
      do_reset(0, 0);
      check("R1 atm hs_out", 32'(hs_out), 1);
      check("R1 tx_data", 32'(tx_data), 0);
      check("R1 tx_soc", 32'(tx_soc), 0);
      check("R1 in_ready", 32'(in_ready), 1);
      do_reset(1, 0);
      check("R1 phy hs_out", 32'(hs_out), 0);
   endtask

   task automatic t_partial;
      do_reset(0, 0);
      partner_on = 1;
      for (int k = 0; k < 51; k++) put_oct(co(5, k));
      idle(10);
      check("R3 no words on partial cell", 32'(cap_n), 0);
      check("R3 hs_out idle", 32'(hs_out), 1);
      put_oct(co(5, 51));
      idle(70);
      check("R3 R8 cell count 8-bit", 32'(cap_n), 53);
      verify("R4 R6 R7 8-bit atm", 5, 1, 0);
   endtask

   task automatic t_wide_phy;
      do_reset(1, 1);
      put_cell(9);
      put_cell(10);
      idle(5);
      check("R8 no move without partner", 32'(cap_n), 0);
      check("R8 phy cell-available", 32'(hs_out), 1);
      partner_on = 1;
      idle(70);
      check("R5 words for two cells", 32'(cap_n), 54);
      verify("R5 R6 R7 16-bit phy", 9, 2, 1);
      check("R11 back-to-back gap", 32'(cap_cyc[27] - cap_cyc[26]), 1);
      check("R1 phy idle after drain", 32'(hs_out), 0);
   endtask

   task automatic t_stall;
      do_reset(0, 1);
      put_cell(20);
      put_cell(21);
      stall_en = 1;
      partner_on = 1;
      idle(150);
      check("R9 words after stalls", 32'(cap_n), 54);
      verify("R9 resume order", 20, 2, 1);
      check("R9 held words stable", 32'(hold_bad), 0);
      check("R9 stalls seen", 32'(hold_seen > 10), 1);
   endtask

   task automatic t_cfg_frozen;
      do_reset(0, 0);
      cfg_phy_side = 1;
      cfg_wide_bus = 1;
      put_cell(33);
      partner_on = 1;
      idle(70);
      check("R2 still 8-bit", 32'(cap_n), 53);
      verify("R2 layout kept", 33, 1, 0);
      check("R2 atm polarity kept", 32'(hs_out), 1);
      cfg_phy_side = 0;
      cfg_wide_bus = 0;
   endtask

   task automatic t_full;
      int soc_n = 0;
      do_reset(0, 0);
      for (int c = 0; c < 32; c++) begin
         if (c == 31) begin
            for (int k = 0; k < 51; k++) put_oct(co(40 + c, k));
            @(negedge clk);
            check("R10 ready before last octet", 32'(in_ready), 1);
            put_oct(co(40 + c, 51));
         end else begin
            put_cell(40 + c);
         end
      end
      @(negedge clk);
      check("R10 full store not ready", 32'(in_ready), 0);
      partner_on = 1;
      idle(32 * 53 + 40);
      check("R10 R11 drained words", 32'(cap_n), 32 * 53);
      for (int i = 0; i < 32 * 53; i++) if (cap[i][16]) soc_n++;
      check("R7 start markers", 32'(soc_n), 32);
      verify("R11 cells whole", 40, 32, 0);
      check("R10 ready after drain", 32'(in_ready), 1);
   endtask

   initial begin
      t_reset;
      t_partial;
      t_wide_phy;
      t_stall;
      t_cfg_frozen;
      t_full;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule